// File: doc/BRIEF.md
# Packed Multiply-Add Dot-Product Unit

A SIMD integer datapath for signal and pixel kernels. Two 64-bit operand buses each carry four signed 16-bit words. In the pair-sum operation every word of one operand is multiplied by the word in the same lane of the other, and neighbouring products are added into two 32-bit sums. In the high-half operation the unit returns bits 31:16 of each 32-bit product, giving four words.

A sequenced mode builds an eight-term dot product from two operand beats. The first beat arrives with the start pulse and the second on the next cycle. Each beat is reduced to two pair sums. One more cycle adds all four partial sums into a single 32-bit scalar. The handshake is a start pulse, a busy level and a one-cycle done strobe that comes with the result.

Top module: `pmadd_unit`

## Requirements
- R1: With mode 2'b00, result bits 31:0 equal a0*b0+a1*b1 and bits 63:32 equal a2*b2+a3*b3, where word k occupies operand bits 16k+15:16k and all words are signed.
- R2: Each pair sum wraps modulo 2^32. When all four words of one pair are -32768 (16'h8000), the sum is 32'h80000000.
- R3: With mode 2'b01, result word k (bits 16k+15:16k) equals bits 31:16 of the signed 32-bit product ak*bk.
- R4: Mode 2'b11 behaves exactly like mode 2'b00. Mode 2'b10 selects the dot-product sequence.
- R5: A pair-sum or high-half start accepted while idle raises done_o for exactly the next cycle, with the result on result_o. busy_o stays low.
- R6: A dot-product start takes the first four element pairs from the operand buses in the start cycle and the next four in the following cycle. done_o rises two cycles after that second beat. result_o then holds the modulo-2^32 sum of all eight products in bits 31:0, sign-extended into bits 63:32.
- R7: During a dot product, busy_o is high from the cycle after the accepted start until done_o rises. done_o and busy_o are never high together.
- R8: start_i is ignored while busy_o is high. No extra done_o pulse follows, and result_o is not altered.
- R9: rst_ni low returns the unit to idle at once, with busy_o, done_o and result_o at zero. Any sequence in progress is abandoned and the partial sums are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an operation (sampled only while idle) |
| mode_i | input | 2 | 00 pair-sum, 01 high-half, 10 dot product, 11 pair-sum |
| opa_i | input | 64 | First operand, four signed 16-bit words |
| opb_i | input | 64 | Second operand, four signed 16-bit words |
| busy_o | output | 1 | Dot-product sequence in progress |
| done_o | output | 1 | One-cycle strobe: result_o is new |
| result_o | output | 64 | Packed sums, packed high words, or sign-extended scalar |

## Verification
The hardest case to reach is a start pulse that lands inside a running dot product. The unit must neither restart nor emit a second strobe, and it must still take the second-beat operands. The stimulus holds start_i high with a different mode during both busy cycles. It then checks that the scalar is correct and that no strobe follows. A reset that arrives between the two beats is also hard to reach. It is driven mid-sequence, and a fresh dot product afterwards shows that no stale partial sum survived. Beats made only of -32768 words exercise the wrap in the pair sums and in the final add.

// File: rtl/pmadd_pkg.sv
package pmadd_pkg;
  typedef enum logic [1:0] {
    MODE_MADD     = 2'b00,
    MODE_MULH     = 2'b01,
    MODE_DOT      = 2'b10,
    MODE_MADD_ALT = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BEAT2 = 2'b01,
    ST_FINAL = 2'b10
  } seq_state_e;
endpackage

// File: rtl/pmadd_mul_lanes.sv
module pmadd_mul_lanes #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic [DATA_W-1:0]       a_i,
  input  logic [DATA_W-1:0]       b_i,
  output logic [LANES*PROD_W-1:0] prod_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [PROD_W-1:0] ext_a, ext_b, prod;
    assign ext_a = PROD_W'($signed(a_i[k*WORD_W +: WORD_W]));
    assign ext_b = PROD_W'($signed(b_i[k*WORD_W +: WORD_W]));
    assign prod  = ext_a * ext_b;
    assign prod_o[k*PROD_W +: PROD_W] = prod;
  end
endmodule

// File: rtl/pmadd_combine.sv
module pmadd_combine #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int PAIRS  = LANES / 2,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic [LANES*PROD_W-1:0] prod_i,
  output logic [PAIRS*PROD_W-1:0] pair_o,
  output logic [DATA_W-1:0]       high_o
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    // wraps modulo 2^PROD_W
    assign pair_o[p*PROD_W +: PROD_W] = prod_i[(2*p)*PROD_W +: PROD_W]
                                      + prod_i[(2*p+1)*PROD_W +: PROD_W];
  end
  for (genvar k = 0; k < LANES; k++) begin : g_high
    assign high_o[k*WORD_W +: WORD_W] = prod_i[k*PROD_W+WORD_W +: WORD_W];
  end
endmodule

// File: rtl/pmadd_seq.sv
module pmadd_seq
  import pmadd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int PAIRS  = LANES / 2,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              mode_i,
  input  logic [PAIRS*PROD_W-1:0] pair_i,
  input  logic [DATA_W-1:0]       high_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [DATA_W-1:0]       result_o
);
  seq_state_e              state_q;
  logic [PAIRS*PROD_W-1:0] beat1_q, beat2_q;
  logic [DATA_W-1:0]       result_q;
  logic                    done_q;
  logic [PROD_W-1:0]       scalar;
  mode_e                   mode;

  assign mode = mode_e'(mode_i);

  always_comb begin
    scalar = '0;
    for (int p = 0; p < PAIRS; p++) begin
      scalar = scalar + beat1_q[p*PROD_W +: PROD_W] + beat2_q[p*PROD_W +: PROD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      beat1_q  <= '0;
      beat2_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            case (mode)
              MODE_MULH: begin
                result_q <= high_i;
                done_q   <= 1'b1;
              end
              MODE_DOT: begin
                beat1_q <= pair_i;
                state_q <= ST_BEAT2;
              end
              default: begin
                result_q <= DATA_W'(pair_i);
                done_q   <= 1'b1;
              end
            endcase
          end
        end
        ST_BEAT2: begin
          beat2_q <= pair_i;
          state_q <= ST_FINAL;
        end
        ST_FINAL: begin
          result_q <= {{(DATA_W-PROD_W){scalar[PROD_W-1]}}, scalar};
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/pmadd_unit.sv
module pmadd_unit #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int PAIRS  = LANES / 2,
  localparam int DATA_W = LANES * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  logic [LANES*PROD_W-1:0] prod;
  logic [PAIRS*PROD_W-1:0] pair;
  logic [DATA_W-1:0]       high;

  pmadd_mul_lanes #(.LANES(LANES), .WORD_W(WORD_W)) i_mul (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .prod_o (prod)
  );

  pmadd_combine #(.LANES(LANES), .WORD_W(WORD_W)) i_combine (
    .prod_i (prod),
    .pair_o (pair),
    .high_o (high)
  );

  pmadd_seq #(.LANES(LANES), .WORD_W(WORD_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .pair_i   (pair),
    .high_i   (high),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );
endmodule

// File: rtl/pmadd_unit_chk.sv
module pmadd_unit_chk #(
  parameter int LANES  = 4,
  parameter int WORD_W = 16,
  localparam int PROD_W = 2 * WORD_W,
  localparam int DATA_W = LANES * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        mode_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o
);
  function automatic logic [PROD_W-1:0] smul(input logic [WORD_W-1:0] x, input logic [WORD_W-1:0] y);
    logic signed [PROD_W-1:0] ex, ey;
    ex = PROD_W'($signed(x));
    ey = PROD_W'($signed(y));
    return ex * ey;
  endfunction

  logic idle_madd, idle_mulh, idle_dot;
  logic [PROD_W-1:0] lane0_sum;
  logic [WORD_W-1:0] lane0_high;
  assign idle_madd  = start_i && !busy_o && !mode_i[1] && !mode_i[0];
  assign idle_mulh  = start_i && !busy_o && !mode_i[1] && mode_i[0];
  assign idle_dot   = start_i && !busy_o && mode_i[1] && !mode_i[0];
  assign lane0_sum  = smul(opa_i[0 +: WORD_W], opb_i[0 +: WORD_W])
                    + smul(opa_i[WORD_W +: WORD_W], opb_i[WORD_W +: WORD_W]);
  assign lane0_high = smul(opa_i[0 +: WORD_W], opb_i[0 +: WORD_W]) >> WORD_W;

  // R1
  a_r1_lane0_pair_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_madd |=> done_o && (result_o[PROD_W-1:0] == $past(lane0_sum)));

  // R3
  a_r3_lane0_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_mulh |=> done_o && (result_o[WORD_W-1:0] == $past(lane0_high)));

  // R6
  a_r6_dot_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_dot |=> busy_o && !done_o);

  // R7
  a_r7_busy_ends_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R7
  a_r7_no_done_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  // R8
  a_r8_result_held_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (done_o || $stable(result_o)));
endmodule

bind pmadd_unit pmadd_unit_chk #(.LANES(LANES), .WORD_W(WORD_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .mode_i   (mode_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/test_pmadd_unit.sv
module test_pmadd_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, 64'h00000035_00000011},
    '{2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0002_0002_0002_0002, 64'hFFFFFFFC_FFFFFFFC},
    '{2'b00, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h80000000_80000000},
    '{2'b01, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h4000_4000_4000_4000},
    '{2'b01, 64'h7FFF_FFFF_0100_0000, 64'h7FFF_0001_0100_1234, 64'h3FFF_FFFF_0001_0000},
    '{2'b11, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, 64'h00000035_00000011}
  };
  localparam string VREQ [NVEC] = '{"R1", "R1", "R2", "R3", "R3", "R4"};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmadd_unit i_pmadd_unit (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic single_op(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] exp, input string req);
    @(negedge clk);
    start_i = 1'b1; mode_i = m; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
    check("R5", "done after single op", 64'(done_o), 64'd1);
    check("R5", "busy after single op", 64'(busy_o), 64'd0);
    check(req, "single op result", result_o, exp);
    @(negedge clk);
    check("R5", "done one cycle only", 64'(done_o), 64'd0);
  endtask

  task automatic run_dot(input logic [63:0] a1, input logic [63:0] b1,
                         input logic [63:0] a2, input logic [63:0] b2,
                         input logic [63:0] exp, input bit poke, input string req);
    logic [63:0] held;
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'b10; opa_i = a1; opb_i = b1;
    @(negedge clk);
    start_i = poke; mode_i = 2'b00; opa_i = a2; opb_i = b2;
    check("R7", "busy in beat 2", 64'(busy_o), 64'd1);
    check("R7", "no done in beat 2", 64'(done_o), 64'd0);
    @(negedge clk);
    start_i = poke; mode_i = 2'b01; opa_i = '1; opb_i = '1;
    check("R7", "busy in final", 64'(busy_o), 64'd1);
    check("R7", "no done in final", 64'(done_o), 64'd0);
    @(negedge clk);
    start_i = 1'b0;
    check("R6", "dot done", 64'(done_o), 64'd1);
    check("R7", "busy dropped at done", 64'(busy_o), 64'd0);
    check(req, "dot result", result_o, exp);
    held = result_o;
    @(negedge clk);
    check(poke ? "R8" : "R6", "no extra done", 64'(done_o), 64'd0);
    check(poke ? "R8" : "R6", "result held", result_o, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "busy in reset", 64'(busy_o), 64'd0);
    check("R9", "done in reset", 64'(done_o), 64'd0);
    check("R9", "result in reset", result_o, 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      single_op(VECS[i].mode, VECS[i].a, VECS[i].b, VECS[i].exp, VREQ[i]);
    end

    // 17+53-2-2 = 66
    run_dot(64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005,
            64'h0001_0001_0001_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h42, 1'b0, "R6");
    // -8, sign-extended
    run_dot(64'hFFFF_FFFF_FFFF_FFFF, 64'h0002_0002_0002_0002,
            64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFF8, 1'b1, "R6");
    // four 32'h80000000 partials wrap to zero
    run_dot(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000,
            64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h0, 1'b0, "R2");

    // R9: reset between the beats
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'b10;
    opa_i = 64'h7FFF_7FFF_7FFF_7FFF; opb_i = 64'h7FFF_7FFF_7FFF_7FFF;
    @(negedge clk);
    start_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R9", "busy after mid reset", 64'(busy_o), 64'd0);
    check("R9", "done after mid reset", 64'(done_o), 64'd0);
    check("R9", "result after mid reset", result_o, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R9", "idle after release", 64'(busy_o), 64'd0);
    run_dot(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0003,
            64'h0, 64'h0, 64'h3, 1'b0, "R9");

    wrap_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end
endmodule